// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side of a parallel NOR flash. It decides whether an embedded program or erase operation has finished. A one-cycle `start` pulse begins the job. The poller then reads the status byte in back-to-back pairs and compares bit 6, the toggle bit, of the two reads. If the bit holds still, the operation is reported complete. If it changes, bit 5, the timing-limit flag, decides whether polling goes on or a confirming pair is read. The confirming pair is needed because the toggling may stop in the same instant the flag rises. A confirmed failure causes the poller to write the reset command byte F0h, and only then report failure. A programmable count of toggling pairs bounds the job, so the poller cannot hang.

Reads use a valid/ready handshake, and the data comes back in the accepting cycle. A read takes place in every cycle where `rd_valid` and `rd_ready` are both high, with `rd_data` sampled in that cycle. While `rd_ready` is low the poller holds `rd_valid` high and makes no progress. The reset-command write follows the same rule with `wr_valid`, `wr_ready` and `wr_data`. The host may give up at any time during the read phase by raising `abandon`. A later `start` then always begins with a fresh first pair.

Top module: `flash_toggle_poller`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `rd_valid` and `wr_valid` are all 0.
- R2: After `start`, two reads are made. If bit 6 of the second read equals bit 6 of the first, `done` pulses for one cycle, directly after the second read is accepted, and no write occurs. `done` and `fail` are never high together.
- R3: If bit 6 differs and bit 5 of the second read of the pair is 0, a new pair of reads follows. Bit 5 of the first read of the pair has no effect on this decision.
- R4: If bit 6 differs and bit 5 of the second read is 1, a confirming pair is read. If bit 6 is equal across the confirming pair, `done` pulses.
- R5: If bit 6 still differs across the confirming pair, a single write of `wr_data` = F0h is issued. `fail` pulses in the cycle after that write is accepted.
- R6: A toggling pair with bit 5 = 0 that is the `max_polls`-th such pair of the job (values 0 and 1 both act as 1) takes the R5 failure path instead of reading again.
- R7: `rd_valid` stays high while `rd_ready` is low, and no read counts until it is accepted. `wr_valid` and `wr_data` hold until `wr_ready`.
- R8: While reads are in progress, `abandon` returns the poller to idle without any `done` or `fail`. This holds even when it coincides with the accepted final read of a pair. The next `start` begins with a new first pair.
- R9: `abandon` has no effect while the reset write is pending. The write completes and `fail` still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a status-polling job (ignored when busy) |
| abandon | input | 1 | Give up the current job during reads |
| max_polls | input | POLL_W | Allowed number of toggling pairs with flag clear |
| rd_valid | output | 1 | Status read request |
| rd_ready | input | 1 | Read accepted, `rd_data` valid this cycle |
| rd_data | input | DATA_W | Status byte from the flash |
| wr_valid | output | 1 | Command write request |
| wr_ready | input | 1 | Write accepted |
| wr_data | output | DATA_W | Command byte (F0h reset) |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse: operation complete |
| fail | output | 1 | One-cycle pulse: operation failed, reset written |

## Verification
Two functions can land in one clock: the acceptance of the second read of a pair, which would produce a result, and an `abandon` request. The bench stalls the memory model after the first read of a pair. It then releases `rd_ready` and raises `abandon` on the same falling edge. The outcome is judged correct only if neither `done` nor `fail` appears, `busy` drops, and a fresh `start` sequence then produces a normal result. The same collision is provoked against a stalled reset write, where `abandon` must lose and `fail` must still arrive with F0h on the write bus.

// File: rtl/ftp_pkg.sv
package ftp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_A,
    ST_RD_B,
    ST_RC_A,
    ST_RC_B,
    ST_WR_RST
  } ftp_state_t;

  localparam int unsigned TOGGLE_POS = 6;
  localparam int unsigned LIMIT_POS  = 5;
  localparam logic [7:0]  RESET_CMD  = 8'hF0;
endpackage

// File: rtl/ftp_pair_cmp.sv
module ftp_pair_cmp #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TGL    = 6,
  parameter int unsigned LIM    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [DATA_W-1:0] rd_data,
  output logic              toggled,
  output logic              limit_hit
);
  // Only the toggle bit of the first read is needed for the comparison.
  logic first_tgl;

  always_ff @(posedge clk) begin
    if (!rst_n)   first_tgl <= 1'b0;
    else if (cap) first_tgl <= rd_data[TGL];
  end

  assign toggled   = first_tgl ^ rd_data[TGL];
  assign limit_hit = rd_data[LIM];
endmodule

// File: rtl/ftp_poll_cnt.sv
module ftp_poll_cnt #(
  parameter int unsigned POLL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  input  logic [POLL_W-1:0] max_polls,
  output logic              last
);
  localparam logic [POLL_W-1:0] CNT_MAX = {POLL_W{1'b1}};

  logic [POLL_W-1:0] cnt;
  logic [POLL_W:0]   next_cnt;

  assign next_cnt = {1'b0, cnt} + 1'b1;
  assign last     = next_cnt >= {1'b0, max_polls};

  always_ff @(posedge clk) begin
    if (!rst_n || clr)               cnt <= '0;
    else if (inc && cnt != CNT_MAX)  cnt <= next_cnt[POLL_W-1:0];
  end

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !last || max_polls <= 1) else $error("poll count not cleared"); // R6
endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller
  import ftp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned POLL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abandon,
  input  logic [POLL_W-1:0] max_polls,
  output logic              rd_valid,
  input  logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done,
  output logic              fail
);
  ftp_state_t state;
  logic done_q, fail_q;
  logic rd_fire, cap, toggled, limit_hit, last, cnt_inc;

  assign rd_valid = (state == ST_RD_A) || (state == ST_RD_B) ||
                    (state == ST_RC_A) || (state == ST_RC_B);
  assign wr_valid = (state == ST_WR_RST);
  assign wr_data  = DATA_W'(RESET_CMD);
  assign busy     = (state != ST_IDLE);
  assign done     = done_q;
  assign fail     = fail_q;

  assign rd_fire = rd_valid && rd_ready;
  assign cap     = rd_fire && ((state == ST_RD_A) || (state == ST_RC_A));
  assign cnt_inc = rd_fire && !abandon && (state == ST_RD_B) && toggled && !limit_hit;

  ftp_pair_cmp #(.DATA_W(DATA_W), .TGL(TOGGLE_POS), .LIM(LIMIT_POS)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cap(cap), .rd_data(rd_data),
    .toggled(toggled), .limit_hit(limit_hit)
  );

  ftp_poll_cnt #(.POLL_W(POLL_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(state == ST_IDLE), .inc(cnt_inc),
    .max_polls(max_polls), .last(last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      case (state)
        ST_IDLE: if (start) state <= ST_RD_A;
        ST_RD_A: begin
          if (abandon)      state <= ST_IDLE;
          else if (rd_fire) state <= ST_RD_B;
        end
        ST_RD_B: begin
          if (abandon) state <= ST_IDLE;
          else if (rd_fire) begin
            if (!toggled) begin
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else if (limit_hit) state <= ST_RC_A;
            else if (last)          state <= ST_WR_RST;
            else                    state <= ST_RD_A;
          end
        end
        ST_RC_A: begin
          if (abandon)      state <= ST_IDLE;
          else if (rd_fire) state <= ST_RC_B;
        end
        ST_RC_B: begin
          if (abandon) state <= ST_IDLE;
          else if (rd_fire) begin
            if (!toggled) begin
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else state <= ST_WR_RST;
          end
        end
        ST_WR_RST: begin
          if (wr_ready) begin
            fail_q <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !abandon) |=> rd_valid) else $error("read dropped"); // R7
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data))) else $error("write dropped"); // R9
  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail)) else $error("done and fail together"); // R2
  AST_FAIL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> $past(wr_valid && wr_ready)) else $error("fail without write"); // R5
  AST_ABANDON_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (abandon && rd_valid) |=> (!done && !fail && !busy)) else $error("abandon leaked a result"); // R8
  AST_NO_RD_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid)) else $error("read and write together"); // R5
endmodule

// File: tb/flash_toggle_poller_test.sv
`timescale 1ns/1ps
module flash_toggle_poller_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, abandon = 1'b0;
  logic [7:0] max_polls = 8'd15;
  logic rd_valid, rd_ready, wr_valid, wr_ready, busy, done, fail;
  logic [7:0] rd_data, wr_data;

  logic [63:0] script = '0;
  int idx = 0, avail = 64, n_wr = 0;
  logic wr_on = 1'b1;
  logic [7:0] last_wr = '0;
  int n_checks = 0, n_bad = 0, cycles = 0;

  always #2.5 clk = ~clk;

  assign rd_ready = rd_valid && (idx < avail);
  assign rd_data  = (idx < 8) ? script[8*idx +: 8] : 8'h00;
  assign wr_ready = wr_valid && wr_on;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rd_valid && rd_ready) idx <= idx + 1;
    if (wr_valid && wr_ready) begin
      n_wr    <= n_wr + 1;
      last_wr <= wr_data;
    end
  end

  flash_toggle_poller #(.DATA_W(8), .POLL_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .abandon(abandon),
    .max_polls(max_polls), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .busy(busy), .done(done), .fail(fail)
  );

  typedef struct packed {
    logic [63:0] s;
    logic [7:0]  maxp;
    logic        is_fail;
    logic [3:0]  reads;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{64'h0000_0000_0000_4040, 8'd15, 1'b0, 4'd2},  // R2 equal pair
    '{64'h0000_0000_0000_4000, 8'd15, 1'b0, 4'd4},  // R3 toggle, flag clear, then equal
    '{64'h0000_0000_0000_2040, 8'd15, 1'b0, 4'd4},  // R4 flag set, confirm stopped
    '{64'h0000_0000_0040_2040, 8'd15, 1'b1, 4'd4},  // R5 flag set, confirm toggling
    '{64'h0000_0000_4000_4000, 8'd2,  1'b1, 4'd4},  // R6 limit of two pairs
    '{64'h0000_6060_0040_4000, 8'd3,  1'b0, 4'd6},  // R6 under limit, then equal
    '{64'h0000_0000_0000_0060, 8'd15, 1'b0, 4'd4}   // R3 flag only in first read
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_result(output logic got_done, output logic got_fail);
    got_done = 1'b0;
    got_fail = 1'b0;
    for (int k = 0; k < 200; k++) begin
      if (done || fail) begin
        got_done = done;
        got_fail = fail;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic load(input logic [63:0] s);
    script = s;
    idx    = 0;
    n_wr   = 0;
  endtask

  initial begin
    logic gd, gf;
    int w0;
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 outputs", {done, fail, rd_valid, wr_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      load(VEC[v].s);
      max_polls = VEC[v].maxp;
      pulse_start();
      wait_result(gd, gf);
      check($sformatf("R2 vector %0d result", v), {gd, gf}, {!VEC[v].is_fail, VEC[v].is_fail});
      check($sformatf("R3 vector %0d reads", v), idx, VEC[v].reads);
      check($sformatf("R5 vector %0d writes", v), n_wr, VEC[v].is_fail ? 1 : 0);
      if (VEC[v].is_fail) check($sformatf("R5 vector %0d cmd", v), last_wr, 8'hF0);
      @(negedge clk);
      check($sformatf("R2 vector %0d pulse width", v), {done, fail, busy}, 0);
    end
    max_polls = 8'd15;

    // R7 back-pressure: stall second read of the pair
    load(64'h4040);
    avail = 1;
    pulse_start();
    repeat (6) @(negedge clk);
    check("R7 read held", rd_valid, 1);
    check("R7 no extra read", idx, 1);
    // R8 abandon in the same cycle as the final read acceptance
    avail = 64;
    abandon = 1'b1;
    @(negedge clk);
    abandon = 1'b0;
    check("R8 no result on collision", {done, fail, busy}, 0);
    check("R8 read consumed", idx, 2);
    repeat (3) @(negedge clk);
    check("R8 stays quiet", {done, fail, busy}, 0);

    // R8 abandon inside the confirming pair, then restart from the top
    load(64'h2040);
    avail = 2;
    pulse_start();
    repeat (5) @(negedge clk);
    abandon = 1'b1;
    @(negedge clk);
    abandon = 1'b0;
    check("R8 idle after abandon", busy, 0);
    load(64'h0000_2040);
    avail = 64;
    pulse_start();
    wait_result(gd, gf);
    check("R8 restart result", {gd, gf}, 2'b10);
    check("R8 restart reads", idx, 4);

    // R9 abandon during a stalled reset write
    load(64'h0040_2040);
    wr_on = 1'b0;
    pulse_start();
    for (int k = 0; k < 40 && !wr_valid; k++) @(negedge clk);
    check("R9 write pending", wr_valid, 1);
    abandon = 1'b1;
    @(negedge clk);
    abandon = 1'b0;
    check("R9 abandon ignored", {busy, wr_valid, wr_data}, {2'b11, 8'hF0});
    w0 = n_wr;
    wr_on = 1'b1;
    wait_result(gd, gf);
    check("R9 fail after write", {gd, gf}, 2'b01);
    check("R9 one write", n_wr - w0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
    $finish;
  end
endmodule